// File: doc/BRIEF.md
# Frame-Buffer Pixel Format Unpacker with Colour Look-Up Table

This block sits between a frame-buffer read engine and a display pipeline. It takes 32-bit words fetched from video memory and turns them into a stream of 24-bit RGB pixels, one pixel for each completed output handshake. A mode input selects how the words are read. In indexed mode each byte picks a colour from a 256-entry look-up table. There are two 16-bit high-colour layouts. In the unpacked true-colour mode each word holds one pixel. In the packed true-colour mode pixels of three bytes cross word boundaries.

All modes share one byte accumulator. Incoming words are appended to it as bytes, lowest-addressed byte first. Each emitted pixel removes as many bytes from the front as the mode needs. The colour table is loaded through a plain write port that may be used at any time. A frame-start pulse or a change of mode throws away any bytes still held, so a new frame or layout always begins on a word boundary.

Top module: `pix_unpack`

## Requirements
- R1: After reset, out_valid_o is 0 and in_ready_o is 1.
- R2: Mode 0 (indexed) gives four pixels per word, byte [7:0] first, then [15:8], [23:16] and [31:24]. Each pixel is the table entry addressed by that byte.
- R3: Mode 1 (15-bit) gives two pixels per word, bits [15:0] first. Within each 16-bit pixel, red is [14:10], green is [9:5] and blue is [4:0], and bit 15 has no effect.
- R4: Mode 2 (16-bit) gives two pixels per word, low half first. Red is [15:11], green is [10:5] and blue is [4:0].
- R5: Mode 3 (unpacked true colour) gives one pixel per word, equal to bits [23:0] (red [23:16], green [15:8], blue [7:0]). Bits [31:24] have no effect.
- R6: Mode 4 (packed true colour) treats the words as a little-endian byte stream. Each pixel is {byte n+2, byte n+1, byte n}, so three words yield four pixels.
- R7: Channels are widened to 8 bits by appending their top bits: a 5-bit value v becomes {v, v[4:2]} and a 6-bit value becomes {v, v[5:4]}. Full-scale codes therefore give 255.
- R8: A table write during the cycle in which an indexed pixel reading that entry is handed over returns the old colour for that pixel. The following pixels see the new colour.
- R9: A frame_start_i pulse discards all held bytes. out_valid_o is 0 in the following cycle, and the next word begins a fresh pixel.
- R10: A change of mode_i discards all held bytes in the same way, without a frame-start pulse.
- R11: While out_valid_o is 1 and out_ready_o... is low, the pixel is held stable. in_ready_o is 1 only when the bytes that remain after the current pop leave room for a full word (at most ACC_BYTES-4, which is 2 by default). The accumulator never holds more than ACC_BYTES bytes.
- R12: Mode codes 5 to 7 behave as mode 3.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously inside |
| mode_i | input | 3 | Pixel layout select (0 indexed, 1 15-bit, 2 16-bit, 3 unpacked, 4 packed) |
| frame_start_i | input | 1 | One-cycle pulse that discards partial state |
| in_valid_i | input | 1 | Input word valid |
| in_data_i | input | 32 | Word read from the frame buffer |
| in_ready_o | output | 1 | Block can take a word this cycle |
| out_valid_o | output | 1 | Pixel available |
| out_rgb_o | output | 24 | Pixel colour {red, green, blue} |
| out_ready_i | input | 1 | Downstream takes the pixel |
| lut_we_i | input | 1 | Colour table write enable |
| lut_addr_i | input | 8 | Colour table write address |
| lut_wdata_i | input | 24 | Colour table write data |

## Verification
The checker watches four things on every cycle. A pixel stalled by backpressure must stay unchanged. The cycle after a frame-start pulse or a mode change must carry no pixel. The byte count must stay within capacity. Every accepted word must leave at least a word's worth of bytes behind. The correctness of the colours themselves can only be shown by the bench's scenarios. These cover the byte order within words, the bit layouts and widening of the 16-bit formats, realignment of packed pixels across words, the old-value rule for a table write that collides with a read, and the fact that discarded leftover bytes never reach a later pixel.

// File: rtl/pix_unpack_pkg.sv
package pix_unpack_pkg;

  typedef enum logic [2:0] {
    PM_IDX8   = 3'd0,
    PM_RGB555 = 3'd1,
    PM_RGB565 = 3'd2,
    PM_XRGB32 = 3'd3,
    PM_RGB24P = 3'd4
  } pix_mode_e;

  // Bytes consumed from the accumulator per emitted pixel.
  function automatic logic [2:0] bytes_per_pix(input logic [2:0] mode);
    case (mode)
      PM_IDX8:   return 3'd1;
      PM_RGB555: return 3'd2;
      PM_RGB565: return 3'd2;
      PM_RGB24P: return 3'd3;
      default:   return 3'd4;
    endcase
  endfunction

endpackage

// File: rtl/pix_widen.sv
// Widens a channel by replicating its most significant bits into the low end.
module pix_widen #(
  parameter int IN_W  = 5,
  parameter int OUT_W = 8
) (
  input  logic [IN_W-1:0]  val_i,
  output logic [OUT_W-1:0] val_o
);
  localparam int PAD_W = OUT_W - IN_W;

  assign val_o = {val_i, val_i[IN_W-1 -: PAD_W]};
endmodule

// File: rtl/pix_clut.sv
// Colour table: synchronous write, combinational read (old data on collision).
module pix_clut #(
  parameter int AW = 8,
  parameter int DW = 24
) (
  input  logic          clk_i,
  input  logic          we_i,
  input  logic [AW-1:0] waddr_i,
  input  logic [DW-1:0] wdata_i,
  input  logic [AW-1:0] raddr_i,
  output logic [DW-1:0] rdata_o
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem_q [DEPTH];

  always_ff @(posedge clk_i) begin
    if (we_i) begin
      mem_q[waddr_i] <= wdata_i;
    end
  end

  assign rdata_o = mem_q[raddr_i];
endmodule

// File: rtl/pix_byte_acc.sv
// Byte accumulator: words enter at the tail, pixels leave from the head.
module pix_byte_acc #(
  parameter int ACC_BYTES  = 6,
  parameter int IN_BYTES   = 4,
  parameter int HEAD_BYTES = 3,
  parameter int CW         = $clog2(ACC_BYTES + 1)
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    flush_i,
  input  logic                    push_i,
  input  logic [8*IN_BYTES-1:0]   push_data_i,
  input  logic                    pop_i,
  input  logic [CW-1:0]           pop_n_i,
  output logic [CW-1:0]           count_o,
  output logic [8*HEAD_BYTES-1:0] head_o
);
  logic [7:0]    byte_q [ACC_BYTES];
  logic [7:0]    byte_d [ACC_BYTES];
  logic [CW-1:0] count_q, count_d;
  logic          en;

  always_comb begin
    int cnt;
    int drop;
    int keep;
    cnt  = int'(count_q);
    drop = pop_i ? int'(pop_n_i) : 0;
    keep = cnt - drop;
    for (int i = 0; i < ACC_BYTES; i++) begin
      if (i + drop < cnt) begin
        byte_d[i] = byte_q[i + drop];
      end else if (push_i && (i >= keep) && (i - keep < IN_BYTES)) begin
        byte_d[i] = push_data_i[8*(i - keep) +: 8];
      end else begin
        byte_d[i] = 8'h00;
      end
    end
    if (flush_i) begin
      count_d = '0;
    end else begin
      count_d = CW'(keep + (push_i ? IN_BYTES : 0));
    end
    en = flush_i | push_i | pop_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      count_q <= '0;
      for (int i = 0; i < ACC_BYTES; i++) begin
        byte_q[i] <= 8'h00;
      end
    end else if (en) begin
      count_q <= count_d;
      for (int i = 0; i < ACC_BYTES; i++) begin
        byte_q[i] <= byte_d[i];
      end
    end
  end

  assign count_o = count_q;

  for (genvar g = 0; g < HEAD_BYTES; g++) begin : g_head
    assign head_o[8*g +: 8] = byte_q[g];
  end
endmodule

// File: rtl/pix_unpack.sv
module pix_unpack
  import pix_unpack_pkg::*;
#(
  parameter int DATA_W    = 32,
  parameter int ACC_BYTES = 6,
  parameter int LUT_AW    = 8,
  parameter int COLOR_W   = 24
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [2:0]         mode_i,
  input  logic               frame_start_i,
  input  logic               in_valid_i,
  input  logic [DATA_W-1:0]  in_data_i,
  output logic               in_ready_o,
  output logic               out_valid_o,
  output logic [COLOR_W-1:0] out_rgb_o,
  input  logic               out_ready_i,
  input  logic               lut_we_i,
  input  logic [LUT_AW-1:0]  lut_addr_i,
  input  logic [COLOR_W-1:0] lut_wdata_i
);
  localparam int IN_BYTES   = DATA_W / 8;
  localparam int CH_W       = COLOR_W / 3;
  localparam int HEAD_BYTES = 3;
  localparam int CW         = $clog2(ACC_BYTES + 1);
  localparam logic [CW-1:0] ROOM = CW'(ACC_BYTES - IN_BYTES);

  // Reset: asynchronous assertion, synchronous release.
  logic rst_meta_q, rst_sync_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rst_meta_q <= 1'b0;
      rst_sync_q <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_q <= rst_meta_q;
    end
  end

  logic [2:0] mode_prev_q;
  always_ff @(posedge clk_i or negedge rst_sync_q) begin
    if (!rst_sync_q) begin
      mode_prev_q <= PM_IDX8;
    end else begin
      mode_prev_q <= mode_i;
    end
  end

  logic                    flush;
  logic [CW-1:0]           bpp;
  logic [CW-1:0]           acc_count;
  logic [CW-1:0]           after_pop;
  logic [8*HEAD_BYTES-1:0] head;
  logic                    pop, push;

  always_comb begin
    flush       = frame_start_i | (mode_i != mode_prev_q);
    bpp         = CW'(bytes_per_pix(mode_i));
    out_valid_o = rst_sync_q & ~flush & (acc_count >= bpp);
    pop         = out_valid_o & out_ready_i;
    after_pop   = pop ? (acc_count - bpp) : acc_count;
    in_ready_o  = rst_sync_q & ~flush & (after_pop <= ROOM);
    push        = in_valid_i & in_ready_o;
  end

  pix_byte_acc #(
    .ACC_BYTES (ACC_BYTES),
    .IN_BYTES  (IN_BYTES),
    .HEAD_BYTES(HEAD_BYTES),
    .CW        (CW)
  ) u_acc (
    .clk_i      (clk_i),
    .rst_ni     (rst_sync_q),
    .flush_i    (flush),
    .push_i     (push),
    .push_data_i(in_data_i),
    .pop_i      (pop),
    .pop_n_i    (bpp),
    .count_o    (acc_count),
    .head_o     (head)
  );

  logic [COLOR_W-1:0] lut_rdata;
  pix_clut #(
    .AW(LUT_AW),
    .DW(COLOR_W)
  ) u_clut (
    .clk_i  (clk_i),
    .we_i   (lut_we_i),
    .waddr_i(lut_addr_i),
    .wdata_i(lut_wdata_i),
    .raddr_i(head[LUT_AW-1:0]),
    .rdata_o(lut_rdata)
  );

  // 15-bit layout: three 5-bit fields, blue at the bottom.
  logic [CH_W-1:0] c555 [3];
  for (genvar g = 0; g < 3; g++) begin : g_w555
    pix_widen #(.IN_W(5), .OUT_W(CH_W)) u_w (
      .val_i(head[5*g +: 5]),
      .val_o(c555[g])
    );
  end

  // 16-bit layout: 5-6-5.
  logic [CH_W-1:0] r565, g565, b565;
  pix_widen #(.IN_W(5), .OUT_W(CH_W)) u_r565 (.val_i(head[15:11]), .val_o(r565));
  pix_widen #(.IN_W(6), .OUT_W(CH_W)) u_g565 (.val_i(head[10:5]),  .val_o(g565));
  pix_widen #(.IN_W(5), .OUT_W(CH_W)) u_b565 (.val_i(head[4:0]),   .val_o(b565));

  always_comb begin
    case (mode_i)
      PM_IDX8:   out_rgb_o = lut_rdata;
      PM_RGB555: out_rgb_o = {c555[2], c555[1], c555[0]};
      PM_RGB565: out_rgb_o = {r565, g565, b565};
      default:   out_rgb_o = head[COLOR_W-1:0];
    endcase
  end
endmodule

// File: rtl/pix_unpack_chk.sv
module pix_unpack_chk #(
  parameter int ACC_BYTES = 6,
  parameter int CW        = 3
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic [2:0]    mode_i,
  input logic          frame_start_i,
  input logic          in_valid_i,
  input logic          in_ready_o,
  input logic          out_valid_o,
  input logic [23:0]   out_rgb_o,
  input logic          out_ready_i,
  input logic          lut_we_i,
  input logic [CW-1:0] acc_count
);
  // R11: a stalled pixel stays put unless a flush or table write intervenes.
  a_r11_hold_stable: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (out_valid_o && !out_ready_i && !lut_we_i) ##1 (!frame_start_i && mode_i == $past(mode_i))
      |-> (out_valid_o && $stable(out_rgb_o)));

  // R9: a frame-start pulse leaves nothing to emit in the next cycle.
  a_r9_frame_flush: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frame_start_i |=> !out_valid_o);

  // R10: a mode change leaves nothing to emit in the next cycle.
  a_r10_mode_flush: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i != $past(mode_i)) |=> !out_valid_o);

  // R11: capacity is never exceeded.
  a_r11_no_overflow: assert property (@(posedge clk_i) disable iff (!rst_ni)
    int'(acc_count) <= ACC_BYTES);

  // R11: an accepted word lands in the accumulator.
  a_r11_push_lands: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (in_valid_i && in_ready_o) |=> int'(acc_count) >= 4);
endmodule

bind pix_unpack pix_unpack_chk #(.ACC_BYTES(ACC_BYTES), .CW(CW)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .mode_i       (mode_i),
  .frame_start_i(frame_start_i),
  .in_valid_i   (in_valid_i),
  .in_ready_o   (in_ready_o),
  .out_valid_o  (out_valid_o),
  .out_rgb_o    (out_rgb_o),
  .out_ready_i  (out_ready_i),
  .lut_we_i     (lut_we_i),
  .acc_count    (acc_count)
);

// File: tb/tb_pix_unpack.sv
`timescale 1ns/1ps
module tb_pix_unpack;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [2:0]  mode;
  logic        frame_start;
  logic        in_valid;
  logic [31:0] in_data;
  logic        in_ready;
  logic        out_valid;
  logic [23:0] out_rgb;
  logic        out_ready;
  logic        lut_we;
  logic [7:0]  lut_addr;
  logic [23:0] lut_wdata;

  int n_chk  = 0;
  int n_fail = 0;

  logic [23:0] got [64];
  int          got_n = 0;

  always #10 clk = ~clk;

  pix_unpack dut (
    .clk_i(clk), .rst_ni(rst_n), .mode_i(mode), .frame_start_i(frame_start),
    .in_valid_i(in_valid), .in_data_i(in_data), .in_ready_o(in_ready),
    .out_valid_o(out_valid), .out_rgb_o(out_rgb), .out_ready_i(out_ready),
    .lut_we_i(lut_we), .lut_addr_i(lut_addr), .lut_wdata_i(lut_wdata)
  );

  // Record every completed output handshake mid-cycle.
  always @(negedge clk) begin
    if (rst_n && out_valid && out_ready) begin
      if (got_n < 64) got[got_n] = out_rgb;
      got_n++;
    end
  end

  function automatic logic [7:0] w5(input logic [4:0] v); return {v, v[4:2]}; endfunction
  function automatic logic [7:0] w6(input logic [5:0] v); return {v, v[5:4]}; endfunction
  function automatic logic [23:0] lutv(input logic [7:0] i); return {i, ~i, i ^ 8'h5a}; endfunction

  task automatic chk(input string tag, input logic [23:0] act, input logic [23:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
  endtask

  task automatic cycles(input int n);
    repeat (n) @(posedge clk);
    #2;
  endtask

  task automatic push_word(input logic [31:0] w);
    logic ok;
    in_valid = 1'b1;
    in_data  = w;
    do begin
      @(negedge clk);
      ok = in_ready;
      @(posedge clk);
      #2;
    end while (!ok);
    in_valid = 1'b0;
  endtask

  task automatic lut_write(input logic [7:0] a, input logic [23:0] d);
    lut_we = 1'b1; lut_addr = a; lut_wdata = d;
    cycles(1);
    lut_we = 1'b0;
  endtask

  task automatic set_mode(input logic [2:0] m);
    mode = m;
    frame_start = 1'b1;
    cycles(1);
    frame_start = 1'b0;
    cycles(1);
  endtask

  task automatic t_reset();
    @(negedge clk);
    chk("R1 out_valid after reset", {23'd0, out_valid}, 24'd0);
    chk("R1 in_ready after reset", {23'd0, in_ready}, 24'd1);
    cycles(1);
  endtask

  task automatic t_idx8();
    int b;
    set_mode(3'd0);
    b = got_n;
    push_word(32'h807f1005);
    cycles(8);
    chk("R2 pixel count", 24'(got_n - b), 24'd4);
    chk("R2 byte0", got[b],   lutv(8'h05));
    chk("R2 byte1", got[b+1], lutv(8'h10));
    chk("R2 byte2", got[b+2], lutv(8'h7f));
    chk("R2 byte3", got[b+3], lutv(8'h80));
  endtask

  task automatic t_rgb555();
    int b;
    set_mode(3'd1);
    b = got_n;
    push_word({16'h06AF, 16'hFC10});
    cycles(6);
    chk("R3 pixel count", 24'(got_n - b), 24'd2);
    chk("R3 R7 low half, bit15 ignored", got[b], {8'hFF, 8'h00, w5(5'h10)});
    chk("R3 R7 high half", got[b+1], {w5(5'h01), w5(5'h15), w5(5'h0F)});
  endtask

  task automatic t_rgb565();
    int b;
    set_mode(3'd2);
    b = got_n;
    push_word({16'h8401, 16'hFFFF});
    cycles(6);
    chk("R4 pixel count", 24'(got_n - b), 24'd2);
    chk("R4 R7 full scale", got[b], 24'hFFFFFF);
    chk("R4 R7 high half", got[b+1], {w5(5'h10), w6(6'h20), w5(5'h01)});
  endtask

  task automatic t_xrgb32();
    int b;
    set_mode(3'd3);
    b = got_n;
    push_word(32'hA5123456);
    push_word(32'hFF000000);
    cycles(6);
    chk("R5 pixel count", 24'(got_n - b), 24'd2);
    chk("R5 low 24 bits", got[b], 24'h123456);
    chk("R5 top byte ignored", got[b+1], 24'h000000);
  endtask

  task automatic t_unused_mode();
    int b;
    set_mode(3'd6);
    b = got_n;
    push_word(32'hEE445566);
    cycles(6);
    chk("R12 pixel count", 24'(got_n - b), 24'd1);
    chk("R12 acts as unpacked", got[b], 24'h445566);
  endtask

  task automatic t_rgb24p();
    int b;
    set_mode(3'd4);
    b = got_n;
    push_word(32'h13121110);
    push_word(32'h17161514);
    push_word(32'h1B1A1918);
    cycles(8);
    chk("R6 pixel count", 24'(got_n - b), 24'd4);
    chk("R6 pixel0", got[b],   24'h121110);
    chk("R6 pixel1", got[b+1], 24'h151413);
    chk("R6 pixel2", got[b+2], 24'h181716);
    chk("R6 pixel3", got[b+3], 24'h1B1A19);
  endtask

  task automatic t_lut_collide();
    int b;
    set_mode(3'd0);
    out_ready = 1'b0;
    b = got_n;
    push_word(32'h33333333);
    cycles(1);
    @(negedge clk);
    chk("R11 valid held under stall", {23'd0, out_valid}, 24'd1);
    chk("R11 in_ready low without room", {23'd0, in_ready}, 24'd0);
    cycles(1);
    lut_we = 1'b1; lut_addr = 8'h33; lut_wdata = 24'h0BEEF0; out_ready = 1'b1;
    cycles(1);
    lut_we = 1'b0;
    cycles(6);
    chk("R8 pixel count", 24'(got_n - b), 24'd4);
    chk("R8 colliding read gives old", got[b], lutv(8'h33));
    chk("R8 next pixel gives new", got[b+1], 24'h0BEEF0);
    chk("R8 later pixel gives new", got[b+3], 24'h0BEEF0);
  endtask

  task automatic t_frame_flush();
    int b;
    set_mode(3'd4);
    b = got_n;
    push_word(32'h33221100);
    cycles(4);
    chk("R9 one pixel before flush", 24'(got_n - b), 24'd1);
    chk("R9 first pixel", got[b], 24'h221100);
    frame_start = 1'b1;
    cycles(1);
    frame_start = 1'b0;
    b = got_n;
    push_word(32'h43424140);
    push_word(32'h47464544);
    push_word(32'h4B4A4948);
    cycles(8);
    chk("R9 pixel count after flush", 24'(got_n - b), 24'd4);
    chk("R9 fresh pixel0", got[b],   24'h424140);
    chk("R9 fresh pixel3", got[b+3], 24'h4B4A49);
  endtask

  task automatic t_mode_flush();
    int b;
    set_mode(3'd4);
    b = got_n;
    push_word(32'h33221100);
    cycles(4);
    chk("R10 one pixel before change", 24'(got_n - b), 24'd1);
    mode = 3'd3;
    cycles(2);
    b = got_n;
    push_word(32'h00ABCDEF);
    cycles(6);
    chk("R10 pixel count after change", 24'(got_n - b), 24'd1);
    chk("R10 leftover byte dropped", got[b], 24'hABCDEF);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog expired actual=running expected=finished");
    summary();
    $finish;
  end

  initial begin
    rst_n = 1'b0; mode = 3'd0; frame_start = 1'b0; in_valid = 1'b0; in_data = '0;
    out_ready = 1'b1; lut_we = 1'b0; lut_addr = '0; lut_wdata = '0;
    repeat (3) @(posedge clk);
    #2 rst_n = 1'b1;
    cycles(4);
    t_reset();
    lut_write(8'h05, lutv(8'h05));
    lut_write(8'h10, lutv(8'h10));
    lut_write(8'h7f, lutv(8'h7f));
    lut_write(8'h80, lutv(8'h80));
    lut_write(8'h33, lutv(8'h33));
    t_idx8();
    t_rgb555();
    t_rgb565();
    t_xrgb32();
    t_unused_mode();
    t_rgb24p();
    t_lut_collide();
    t_frame_flush();
    t_mode_flush();
    summary();
    $finish;
  end
endmodule